// File: doc/BRIEF.md
# Indirect Channel-Table Access Controller

This block gives a host processor access to a per-channel configuration RAM without ever putting a RAM address on the host bus. The host sees two registers. The first is a 16-bit command/select register. Its low byte names a channel, and one direction bit picks either a fetch from the RAM or a store to it. The second is a data register. It receives the fetched word, or it supplies the word to be stored. A read-only busy flag in the command register shows that an access is still in progress.

The same single-port RAM also serves a datapath. The datapath always wins a cycle it asks for, so a host access waits until the RAM has a free cycle, and its latency varies with datapath load. The host writes a command, then polls busy. When busy falls after a fetch, the data register holds the word. When busy falls after a store, the word has been committed. The meaning of the stored words is outside this block.

Top module: `chan_table_access`

## Requirements
- R1: After synchronous reset, the command register reads 0000h, so busy is 0. The data register reads 0 and `dp_rvalid` is 0.
- R2: In the command register, bits 7:0 select the channel: code n addresses RAM entry n, so 00h is the first channel and FFh is the 256th. Bit 14 is the direction, with 1 meaning fetch and 0 meaning store. Once a command is accepted, the register reads back the channel and the direction. Bits 13:8 always read 0.
- R3: A command with bit 14 = 1, written while busy is 0, sets busy (bit 15) at the next clock edge. With no datapath traffic, busy is 1 for exactly two cycles. When it falls, the data register holds the addressed entry.
- R4: A command with bit 14 = 0, written while busy is 0, sets busy at the next clock edge. With no datapath traffic, busy is 1 for exactly one cycle. When it falls, the addressed entry holds the value the data register had in the cycle the store was granted.
- R5: Bit 15 of the command register is read-only. The value written to bit 15 or to bits 13:8 does not change which access is started.
- R6: In every cycle that `dp_req` is 1, a pending host access is not granted and busy stays 1. The host access is granted in the first cycle with `dp_req` at 0.
- R7: A datapath request with `dp_we` = 0 gives `dp_rvalid` = 1 one cycle later, with `dp_rdata` equal to the addressed entry. A request with `dp_we` = 1 stores `dp_wdata` into the addressed entry.
- R8: A command written while busy is 1 is ignored. The channel and direction do not change, and no extra RAM access takes place.
- R9: Host writes to the data register are ignored while a fetch is pending. When busy falls, the register holds the fetched word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_wr | input | 1 | Write strobe for the command register |
| sel_wdata | input | 16 | Command register write value |
| sel_rdata | output | 16 | Command register: {busy, direction, 6'b0, channel} |
| data_wr | input | 1 | Write strobe for the data register |
| data_wdata | input | DATA_W | Data register write value |
| data_rdata | output | DATA_W | Data register contents |
| dp_req | input | 1 | Datapath RAM request, which has priority |
| dp_we | input | 1 | Datapath request is a store |
| dp_addr | input | ADDR_W | Datapath entry index |
| dp_wdata | input | DATA_W | Datapath store word |
| dp_rdata | output | DATA_W | Datapath fetch word |
| dp_rvalid | output | 1 | `dp_rdata` is valid, one cycle after a fetch request |

## Verification
A wrong sequencer state shows up at the ports within one or two cycles:
- busy stays high past its fixed one-cycle or two-cycle window, or falls early;
- or busy falls while the data register still holds a stale or overwritten word.

A wrong arbitration decision damages an entry silently. It becomes visible only when that entry is read back later, through either port. For that reason, every entry is written and then read back through both the host path and the datapath.

// File: rtl/cta_pkg.sv
package cta_pkg;
  localparam int SEL_W    = 16;
  localparam int CHF_W    = 8;
  localparam int BIT_DIR  = 14;
  localparam int BIT_BUSY = 15;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RD_REQ = 2'd1,
    ST_RD_CAP = 2'd2,
    ST_WR_REQ = 2'd3
  } cta_state_e;
endpackage

// File: rtl/cta_ram.sv
module cta_ram #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // single port, registered read: block RAM friendly
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    q         <= mem[addr];
    end
  end
endmodule

// File: rtl/cta_arbiter.sv
module cta_arbiter #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dp_req,
  input  logic              dp_we,
  input  logic [ADDR_W-1:0] dp_addr,
  input  logic [DATA_W-1:0] dp_wdata,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_gnt,
  output logic              ram_en,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              dp_rvalid
);
  // datapath has fixed priority; host takes only idle cycles
  always_comb begin
    host_gnt = host_req & ~dp_req;
    ram_en   = dp_req | host_req;
    if (dp_req) begin
      ram_we    = dp_we;
      ram_addr  = dp_addr;
      ram_wdata = dp_wdata;
    end else begin
      ram_we    = host_we;
      ram_addr  = host_addr;
      ram_wdata = host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dp_rvalid <= 1'b0;
    else     dp_rvalid <= dp_req & ~dp_we;
  end
endmodule

// File: rtl/cta_host_regs.sv
module cta_host_regs
  import cta_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_wr,
  input  logic [SEL_W-1:0]  sel_wdata,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_wdata,
  output logic [SEL_W-1:0]  sel_rdata,
  output logic [DATA_W-1:0] data_rdata,
  output logic              host_req,
  output logic              host_we,
  output logic [ADDR_W-1:0] host_addr,
  output logic [DATA_W-1:0] host_wdata,
  input  logic              host_gnt,
  input  logic [DATA_W-1:0] ram_q
);
  localparam int PAD_W = BIT_DIR - CHF_W;

  cta_state_e        state_q;
  logic [CHF_W-1:0]  chan_q;
  logic              dir_q;
  logic [DATA_W-1:0] data_q;
  logic              fetch_pending;
  logic              unused_sel_bits;

  assign unused_sel_bits = ^{sel_wdata[BIT_BUSY], sel_wdata[BIT_DIR-1:CHF_W]};
  assign fetch_pending   = (state_q == ST_RD_REQ) || (state_q == ST_RD_CAP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      chan_q  <= '0;
      dir_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      if (data_wr && !fetch_pending) data_q <= data_wdata;
      unique case (state_q)
        ST_IDLE: begin
          if (sel_wr) begin
            chan_q  <= sel_wdata[CHF_W-1:0];
            dir_q   <= sel_wdata[BIT_DIR];
            state_q <= sel_wdata[BIT_DIR] ? ST_RD_REQ : ST_WR_REQ;
          end
        end
        ST_RD_REQ: if (host_gnt) state_q <= ST_RD_CAP;
        ST_RD_CAP: begin
          data_q  <= ram_q;
          state_q <= ST_IDLE;
        end
        ST_WR_REQ: if (host_gnt) state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign host_req   = (state_q == ST_RD_REQ) || (state_q == ST_WR_REQ);
  assign host_we    = (state_q == ST_WR_REQ);
  assign host_addr  = chan_q[ADDR_W-1:0];
  assign host_wdata = data_q;
  assign sel_rdata  = {(state_q != ST_IDLE), dir_q, {PAD_W{1'b0}}, chan_q};
  assign data_rdata = data_q;
endmodule

// File: rtl/chan_table_access.sv
module chan_table_access
  import cta_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_wr,
  input  logic [15:0]       sel_wdata,
  output logic [15:0]       sel_rdata,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] data_wdata,
  output logic [DATA_W-1:0] data_rdata,
  input  logic              dp_req,
  input  logic              dp_we,
  input  logic [ADDR_W-1:0] dp_addr,
  input  logic [DATA_W-1:0] dp_wdata,
  output logic [DATA_W-1:0] dp_rdata,
  output logic              dp_rvalid
);
  logic              host_req, host_we, host_gnt;
  logic [ADDR_W-1:0] host_addr;
  logic [DATA_W-1:0] host_wdata;
  logic              ram_en, ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata, ram_q;

  cta_host_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .data_wr(data_wr), .data_wdata(data_wdata),
    .sel_rdata(sel_rdata), .data_rdata(data_rdata),
    .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_gnt(host_gnt), .ram_q(ram_q)
  );

  cta_arbiter #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_arb (
    .clk(clk), .rst(rst),
    .dp_req(dp_req), .dp_we(dp_we), .dp_addr(dp_addr), .dp_wdata(dp_wdata),
    .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata),
    .host_gnt(host_gnt),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .dp_rvalid(dp_rvalid)
  );

  cta_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we),
    .addr(ram_addr), .wdata(ram_wdata), .q(ram_q)
  );

  assign dp_rdata = ram_q;
endmodule

// File: rtl/cta_checker.sv
module cta_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              sel_wr,
  input logic              data_wr,
  input logic              dp_req,
  input logic              dp_we,
  input logic [15:0]       sel_rdata,
  input logic [DATA_W-1:0] data_rdata,
  input logic              dp_rvalid
);
  logic busy, dir;
  assign busy = sel_rdata[15];
  assign dir  = sel_rdata[14];

  p_busy_set_r3: assert property (@(posedge clk) disable iff (rst)
    (sel_wr && !busy) |=> busy);

  p_store_done_r4: assert property (@(posedge clk) disable iff (rst)
    (busy && !dir && !dp_req) |=> !busy);

  p_dp_priority_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && !dir && dp_req) |=> busy);

  p_cmd_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && sel_wr) |=> $stable(sel_rdata[13:0]));

  p_data_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && dir && data_wr) |=> ($stable(data_rdata) || !busy));

  p_rvalid_r7: assert property (@(posedge clk) disable iff (rst)
    (dp_req && !dp_we) |=> dp_rvalid);
endmodule

bind chan_table_access cta_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .sel_wr(sel_wr), .data_wr(data_wr),
  .dp_req(dp_req), .dp_we(dp_we), .sel_rdata(sel_rdata),
  .data_rdata(data_rdata), .dp_rvalid(dp_rvalid)
);

// File: tb/chan_table_access_test.sv
module chan_table_access_test;
  localparam int DW = 32;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sel_wr = 1'b0;
  logic [15:0]   sel_wdata = '0;
  logic [15:0]   sel_rdata;
  logic          data_wr = 1'b0;
  logic [DW-1:0] data_wdata = '0;
  logic [DW-1:0] data_rdata;
  logic          dp_req = 1'b0, dp_we = 1'b0;
  logic [AW-1:0] dp_addr = '0;
  logic [DW-1:0] dp_wdata = '0;
  logic [DW-1:0] dp_rdata;
  logic          dp_rvalid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  chan_table_access #(.DATA_W(DW), .ADDR_W(AW)) uut (.*);

  function automatic logic [31:0] pat_a(input logic [7:0] c);
    return {~c, c, c ^ 8'hA5, c + 8'h3C};
  endfunction
  function automatic logic [31:0] pat_b(input logic [7:0] c);
    return {c + 8'h11, 8'h5A ^ c, ~c, c};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_data(input logic [31:0] d);
    @(negedge clk); data_wr = 1'b1; data_wdata = d;
    @(negedge clk); data_wr = 1'b0;
  endtask

  // store command; junk=1 also sets bit 15 and bits 13:8
  task automatic host_store(input logic [7:0] c, input logic [31:0] d, input bit junk);
    logic [15:0] expsel;
    load_data(d);
    sel_wr = 1'b1; sel_wdata = {junk, 1'b0, {6{junk}}, c};
    @(negedge clk); sel_wr = 1'b0;
    expsel = {1'b1, 1'b0, 6'b0, c};
    check(sel_rdata == expsel, "R2/R5 store readback", {16'h0, sel_rdata}, {16'h0, expsel});
    @(negedge clk);
    check(sel_rdata[15] == 1'b0, "R4 busy one cycle", {31'h0, sel_rdata[15]}, 32'h0);
  endtask

  task automatic host_fetch(input logic [7:0] c, input logic [31:0] exp);
    @(negedge clk); sel_wr = 1'b1; sel_wdata = {2'b01, 6'b0, c};
    @(negedge clk); sel_wr = 1'b0;
    check(sel_rdata == {2'b11, 6'b0, c}, "R2/R3 fetch readback", {16'h0, sel_rdata}, {16'h0, 2'b11, 6'b0, c});
    @(negedge clk);
    check(sel_rdata[15] == 1'b1, "R3 busy second cycle", {31'h0, sel_rdata[15]}, 32'h1);
    @(negedge clk);
    check(sel_rdata[15] == 1'b0, "R3 busy cleared", {31'h0, sel_rdata[15]}, 32'h0);
    check(data_rdata == exp, "R3 fetched word", data_rdata, exp);
  endtask

  task automatic dp_fetch(input logic [7:0] c, input logic [31:0] exp, input string req);
    @(negedge clk); dp_req = 1'b1; dp_we = 1'b0; dp_addr = c;
    @(negedge clk); dp_req = 1'b0;
    check(dp_rvalid == 1'b1, "R7 rvalid", {31'h0, dp_rvalid}, 32'h1);
    check(dp_rdata == exp, req, dp_rdata, exp);
  endtask

  task automatic dp_store(input logic [7:0] c, input logic [31:0] d);
    @(negedge clk); dp_req = 1'b1; dp_we = 1'b1; dp_addr = c; dp_wdata = d;
    @(negedge clk); dp_req = 1'b0; dp_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(sel_rdata == 16'h0, "R1 select reset", {16'h0, sel_rdata}, 32'h0);
    check(data_rdata == '0, "R1 data reset", data_rdata, 32'h0);
    check(dp_rvalid == 1'b0, "R1 rvalid reset", {31'h0, dp_rvalid}, 32'h0);

    // R4/R5 host stores over every entry, odd channels with junk bits
    for (int c = 0; c < 256; c++) host_store(8'(c), pat_a(8'(c)), c[0]);
    // R7 datapath sees host stores
    for (int c = 0; c < 256; c++) dp_fetch(8'(c), pat_a(8'(c)), "R4/R7 dp sees host store");
    // R7 datapath stores, R3 host fetches them
    for (int c = 0; c < 256; c++) dp_store(8'(c), pat_b(8'(c)));
    for (int c = 0; c < 256; c++) host_fetch(8'(c), pat_b(8'(c)));

    // R6 contention on a store: datapath held 4 extra cycles
    load_data(32'hC0FFEE05);
    sel_wr = 1'b1; sel_wdata = 16'h0005; dp_req = 1'b1; dp_we = 1'b0; dp_addr = 8'd9;
    @(negedge clk); sel_wr = 1'b0;
    check(sel_rdata[15] == 1'b1, "R6 busy set", {31'h0, sel_rdata[15]}, 32'h1);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(sel_rdata[15] == 1'b1, "R6 host held off", {31'h0, sel_rdata[15]}, 32'h1);
    end
    dp_req = 1'b0;
    @(negedge clk);
    check(sel_rdata[15] == 1'b0, "R6 store after release", {31'h0, sel_rdata[15]}, 32'h0);
    dp_fetch(8'd5, 32'hC0FFEE05, "R6 store committed");
    dp_fetch(8'd9, pat_b(8'd9), "R6 dp entry intact");

    // R6 contention on a fetch
    @(negedge clk); sel_wr = 1'b1; sel_wdata = 16'h4007; dp_req = 1'b1; dp_addr = 8'd3;
    @(negedge clk); sel_wr = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(sel_rdata[15] == 1'b1, "R6 fetch held off", {31'h0, sel_rdata[15]}, 32'h1);
    end
    dp_req = 1'b0;
    @(negedge clk);
    check(sel_rdata[15] == 1'b1, "R6 fetch capture cycle", {31'h0, sel_rdata[15]}, 32'h1);
    @(negedge clk);
    check(sel_rdata[15] == 1'b0, "R6 fetch done", {31'h0, sel_rdata[15]}, 32'h0);
    check(data_rdata == pat_b(8'd7), "R6 fetch word", data_rdata, pat_b(8'd7));

    // R8/R9: command and data write during a pending fetch
    @(negedge clk); sel_wr = 1'b1; sel_wdata = 16'h400A;
    @(negedge clk); sel_wdata = 16'h0014; data_wr = 1'b1; data_wdata = 32'hDEADBEEF;
    @(negedge clk); sel_wr = 1'b0; data_wr = 1'b0;
    check(sel_rdata == 16'hC00A, "R8 command ignored", {16'h0, sel_rdata}, 32'h0000C00A);
    @(negedge clk);
    check(sel_rdata == 16'h400A, "R8 fetch completes", {16'h0, sel_rdata}, 32'h0000400A);
    check(data_rdata == pat_b(8'd10), "R9 data write ignored", data_rdata, pat_b(8'd10));
    dp_fetch(8'd20, pat_b(8'd20), "R8 no stray store");
    dp_fetch(8'd10, pat_b(8'd10), "R8 entry intact");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule